// File: doc/BRIEF.md
# Descriptor Ring Walker

This block keeps a small on-chip table of frame descriptors and walks two rings through it: one for outgoing frames and one for incoming frames. A host fills descriptors through a 32-bit word-addressed register port. It marks outgoing descriptors as ready and incoming ones as empty, then collects the written-back status words. The split between the two rings is programmable. The outgoing ring occupies the first entries of the table, and the incoming ring takes every entry after it.

On the outgoing side, the walker latches the length, buffer address and option bits of the next ready descriptor and presents them on a launch handshake. When the frame engine reports completion, the walker folds the result flags into the status word and clears the ready bit. On the incoming side, each received frame is stored into the next empty descriptor as a length plus error flags, and the empty bit is cleared. If no empty descriptor is available, the frame is reported as dropped. Completion and drop events set bits in a sticky event register, and a host mask gates these bits onto one interrupt line.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, the event register and the mask read 0, the outgoing-ring size reads NUM_BD/2, every descriptor word reads 0, `tx_valid` is low and `irq` is low.
- R2: Host map (byte addresses): 0x000 events, 0x004 mask, 0x008 outgoing-ring size. The size is clamped to NUM_BD when a larger value is written, and a write to it restarts the outgoing pointer at entry 0 and the incoming pointer at the first incoming entry. Descriptor i has its status word at 0x400+8i and its address word at 0x404+8i.
- R3: When the outgoing descriptor under the pointer has status bit 15 (ready) set, `tx_valid` rises with `tx_len` = status[31:16], `tx_addr` = the address word and `tx_crc` = status bit 11. These values are held until `tx_done`.
- R4: `tx_pad` is 1 exactly when status bit 12 is set and the length is below 64.
- R5: On outgoing completion, status bits 8:0 are replaced by `tx_result` and bit 15 is cleared. Bits 14:9 and 31:16 keep their values. `tx_result` fields: bit 8 underrun, bits 7:4 retry count, bit 3 retry limit, bit 2 late collision, bit 1 deferred, bit 0 carrier lost.
- R6: After a completion, the outgoing pointer returns to entry 0 if status bit 13 (wrap) was set or the entry was the last of the ring; otherwise it moves to the next entry. A descriptor that is not ready holds the pointer: no later entry is launched.
- R7: A received frame arriving while the incoming descriptor under the pointer has bit 15 (empty) set is stored as follows: `rx_len` goes to bits 31:16, `rx_flags` goes to bits 8:0 and bit 15 is cleared. The pointer then returns to the first incoming entry on wrap (bit 13) or at the table end, and otherwise moves to the next entry. `rx_flags` fields: 8 control frame, 7 miss, 6 overrun, 5 bad symbol, 4 odd nibble, 3 too long, 2 too short, 1 CRC error, 0 late collision.
- R8: A frame arriving when the current incoming descriptor is not empty, the incoming ring has no entries, or a store is still pending sets event bit 4. No descriptor changes.
- R9: A completion whose descriptor has status bit 14 set raises an event. For outgoing frames this is bit 0, or bit 1 if any of result bits 8, 3, 2 or 0 is set. For incoming frames this is bit 2, or bit 3 if any of flag bits 7:0 is set. With bit 14 clear, no event bit is set.
- R10: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R11: `irq` is high exactly when some event bit and its mask bit are both set.
- R12: A descriptor write-back is held off in every cycle in which the host accesses the descriptor region. It completes on the first clock edge without such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access this cycle |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the access cycle |
| tx_valid | output | 1 | Outgoing frame launched and waiting for completion |
| tx_len | output | 16 | Outgoing frame length |
| tx_addr | output | 32 | Outgoing buffer address |
| tx_pad | output | 1 | Frame must be padded to 64 bytes |
| tx_crc | output | 1 | Frame check sequence to be appended |
| tx_done | input | 1 | Outgoing frame finished |
| tx_result | input | 9 | Outgoing result flags |
| rx_valid | input | 1 | One received frame reported this cycle |
| rx_len | input | 16 | Received length |
| rx_flags | input | 9 | Received error and type flags |
| irq | output | 1 | Masked interrupt |

## Verification
A corrupted ring pointer shows up at the ports on the next launch. Either `tx_addr` belongs to the wrong descriptor, or a stored incoming status appears at an unexpected table address when it is read back. A wrong event bit or a late write-back makes `irq` disagree with the bench's own event model on the very clock edge where the event should land, because that line is compared every cycle. A write-back that merges fields wrongly is caught by the status word read back after each completion.

// File: rtl/bd_ring_seq.sv
module bd_ring_seq #(
  parameter int NUM_BD = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [10:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  output logic [15:0] tx_len,
  output logic [31:0] tx_addr,
  output logic        tx_pad,
  output logic        tx_crc,
  input  logic        tx_done,
  input  logic [8:0]  tx_result,
  input  logic        rx_valid,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_flags,
  output logic        irq
);
  localparam int IW = $clog2(NUM_BD);
  localparam int CW = IW + 1;

  typedef enum logic [1:0] {T_POLL, T_WAIT, T_WB} tx_st_t;

  logic [31:0]   stat_q [NUM_BD];
  logic [31:0]   addr_q [NUM_BD];
  logic [CW-1:0] txnum_q;
  logic [IW-1:0] tx_ptr, rx_ptr;
  logic [4:0]    src_q, mask_q;
  tx_st_t        tst;
  logic [15:0]   tx_len_q;
  logic [31:0]   tx_addr_q;
  logic          tx_pad_q, tx_crc_q;
  logic [8:0]    tx_res_q;
  logic          rx_pend;
  logic [15:0]   rx_len_q;
  logic [8:0]    rx_err_q;

  wire          host_bd  = host_req && host_addr[10];
  wire          host_reg = host_req && !host_addr[10];
  wire [IW-1:0] h_idx    = host_addr[3 +: IW];
  wire [1:0]    h_reg    = host_addr[3:2];
  wire          num_wr   = host_reg && host_we && h_reg == 2'd2;
  wire [CW-1:0] num_new  = (host_wdata > NUM_BD) ? CW'(NUM_BD) : host_wdata[CW-1:0];
  wire [IW-1:0] rx_first = txnum_q[IW-1:0];
  wire          rx_has   = txnum_q < CW'(NUM_BD);

  wire [31:0] tx_stat = stat_q[tx_ptr];
  wire [31:0] rx_stat = stat_q[rx_ptr];

  wire tx_go   = tst == T_POLL && txnum_q != '0 && tx_stat[15];
  wire tx_wr   = tst == T_WB && !host_bd;
  wire rx_take = rx_valid && !rx_pend && rx_has && rx_stat[15];
  wire rx_busy = rx_valid && !rx_take;
  wire rx_wr   = rx_pend && !host_bd;

  wire tx_last = tx_stat[13] || ({1'b0, tx_ptr} == txnum_q - 1'b1);
  wire rx_last = rx_stat[13] || (rx_ptr == IW'(NUM_BD - 1));
  wire tx_ev   = tx_wr && tx_stat[14];
  wire rx_ev   = rx_wr && rx_stat[14];
  wire tx_bad  = tx_res_q[8] | tx_res_q[3] | tx_res_q[2] | tx_res_q[0];
  wire rx_bad  = |rx_err_q[7:0];

  wire [4:0] ev_set = {rx_busy, rx_ev & rx_bad, rx_ev & ~rx_bad, tx_ev & tx_bad, tx_ev & ~tx_bad};
  wire [4:0] ev_clr = (host_reg && host_we && h_reg == 2'd0) ? host_wdata[4:0] : 5'd0;

  wire unused_ok = ^{host_addr, host_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      if (host_bd && host_we) begin
        if (host_addr[2]) addr_q[h_idx] <= host_wdata;
        else              stat_q[h_idx] <= host_wdata;
      end
      if (tx_wr) stat_q[tx_ptr] <= {tx_stat[31:16], 1'b0, tx_stat[14:9], tx_res_q};
      if (rx_wr) stat_q[rx_ptr] <= {rx_len_q, 1'b0, rx_stat[14:9], rx_err_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      mask_q  <= '0;
      txnum_q <= CW'(NUM_BD / 2);
    end else begin
      src_q <= (src_q & ~ev_clr) | ev_set;
      if (host_reg && host_we && h_reg == 2'd1) mask_q <= host_wdata[4:0];
      if (num_wr) txnum_q <= num_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tst       <= T_POLL;
      tx_ptr    <= '0;
      tx_len_q  <= '0;
      tx_addr_q <= '0;
      tx_pad_q  <= 1'b0;
      tx_crc_q  <= 1'b0;
      tx_res_q  <= '0;
    end else if (num_wr) begin
      tst    <= T_POLL;
      tx_ptr <= '0;
    end else begin
      case (tst)
        T_POLL: if (tx_go) begin
          tst       <= T_WAIT;
          tx_len_q  <= tx_stat[31:16];
          tx_addr_q <= addr_q[tx_ptr];
          tx_pad_q  <= tx_stat[12] && tx_stat[31:16] < 16'd64;
          tx_crc_q  <= tx_stat[11];
        end
        T_WAIT: if (tx_done) begin
          tst      <= T_WB;
          tx_res_q <= tx_result;
        end
        default: if (tx_wr) begin
          tst    <= T_POLL;
          tx_ptr <= tx_last ? '0 : tx_ptr + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ptr   <= IW'(NUM_BD / 2);
      rx_pend  <= 1'b0;
      rx_len_q <= '0;
      rx_err_q <= '0;
    end else if (num_wr) begin
      rx_ptr  <= num_new[IW-1:0];
      rx_pend <= 1'b0;
    end else if (rx_wr) begin
      rx_pend <= 1'b0;
      rx_ptr  <= rx_last ? rx_first : rx_ptr + 1'b1;
    end else if (rx_take) begin
      rx_pend  <= 1'b1;
      rx_len_q <= rx_len;
      rx_err_q <= rx_flags;
    end
  end

  always_comb begin
    if (host_addr[10])
      host_rdata = host_addr[2] ? addr_q[h_idx] : stat_q[h_idx];
    else
      case (h_reg)
        2'd0:    host_rdata = {27'd0, src_q};
        2'd1:    host_rdata = {27'd0, mask_q};
        2'd2:    host_rdata = 32'(txnum_q);
        default: host_rdata = '0;
      endcase
  end

  assign tx_valid = tst == T_WAIT;
  assign tx_len   = tx_len_q;
  assign tx_addr  = tx_addr_q;
  assign tx_pad   = tx_pad_q;
  assign tx_crc   = tx_crc_q;
  assign irq      = |(src_q & mask_q);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done && !num_wr) |=> (tx_valid && $stable(tx_len) && $stable(tx_addr)));

  // R6
  tx_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txnum_q != '0) |-> ({1'b0, tx_ptr} < txnum_q));

  // R7
  rx_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_has |-> ({1'b0, rx_ptr} >= txnum_q));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_pend && !rx_stat[15] && !num_wr) |=> src_q[4]);

  // R12
  host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_bd && !host_we) |=> ((src_q[3:0] & ~$past(src_q[3:0])) == 4'd0));
endmodule

// File: tb/bd_ring_seq_tb.sv
module bd_ring_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_req = 0, host_we = 0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        tx_valid, tx_pad, tx_crc, irq;
  logic [15:0] tx_len;
  logic [31:0] tx_addr;
  logic        tx_done = 0, rx_valid = 0;
  logic [8:0]  tx_result = '0, rx_flags = '0;
  logic [15:0] rx_len = '0;

  int compared = 0, mismatched = 0;
  logic [4:0] m_src = '0, m_mask = '0;
  bit live = 0;

  bd_ring_seq #(.NUM_BD(16)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (live) begin
    compared++;
    if (irq !== |(m_src & m_mask)) begin
      mismatched++;
      $display("FAIL R11 irq per-cycle: actual %0b expected %0b at %0t", irq, |(m_src & m_mask), $time);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d);
    @(posedge clk); #1;
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_req = 0; host_we = 0;
    if (a == 11'h000) m_src = m_src & ~d[4:0];
    if (a == 11'h004) m_mask = d[4:0];
  endtask

  task automatic rd(logic [10:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    host_req = 1; host_we = 0; host_addr = a;
    #2 v = host_rdata;
    @(posedge clk); #1;
    host_req = 0;
  endtask

  task automatic rd_chk(string req, logic [10:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic tx_expect(string req, logic [31:0] a, logic [15:0] len, logic pad, logic crc);
    int n = 0;
    @(negedge clk);
    while (!tx_valid && n < 50) begin @(negedge clk); n++; end
    check({req, " tx_valid"}, 32'(tx_valid), 32'd1);
    check({req, " tx_addr"}, tx_addr, a);
    check({req, " tx_len"}, 32'(tx_len), 32'(len));
    check({req, " tx_pad"}, 32'(tx_pad), 32'(pad));
    check({req, " tx_crc"}, 32'(tx_crc), 32'(crc));
  endtask

  task automatic tx_finish(logic [8:0] res, int bitn);
    @(posedge clk); #1; tx_done = 1; tx_result = res;
    @(posedge clk); #1; tx_done = 0;
    @(posedge clk); #1; if (bitn >= 0) m_src[bitn] = 1'b1;
  endtask

  task automatic rx_frame(logic [15:0] len, logic [8:0] fl, bit busy, int bitn);
    @(posedge clk); #1; rx_valid = 1; rx_len = len; rx_flags = fl;
    @(posedge clk); #1; rx_valid = 0;
    if (busy) m_src[4] = 1'b1;
    else begin
      @(posedge clk); #1; if (bitn >= 0) m_src[bitn] = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    // R1 reset state
    check("R1 tx_valid", 32'(tx_valid), 0);
    rd_chk("R1 events", 11'h000, 0);
    rd_chk("R1 mask", 11'h004, 0);
    rd_chk("R1 ring size", 11'h008, 8);
    rd_chk("R1 descriptor", 11'h418, 0);
    // R2 clamp and split
    wr(11'h008, 200);
    rd_chk("R2 clamp", 11'h008, 16);
    wr(11'h008, 4);
    rd_chk("R2 size", 11'h008, 4);
    wr(11'h004, 5'h1f);

    // R3 R4 R5 R9 plain launch
    wr(11'h404, 32'h1000);
    wr(11'h400, 32'h0064C800);
    tx_expect("R3", 32'h1000, 100, 0, 1);
    tx_finish(9'h000, 0);
    rd_chk("R9 tx ok event", 11'h000, 1);
    rd_chk("R5 writeback", 11'h400, 32'h00644800);
    wr(11'h000, 1);
    rd_chk("R10 clear", 11'h000, 0);

    // R4 padding, R9 error event
    wr(11'h40c, 32'h2000);
    wr(11'h408, 32'h0028D800);
    tx_expect("R4", 32'h2000, 40, 1, 1);
    tx_finish(9'h034, 1);
    rd_chk("R9 tx err event", 11'h000, 2);
    rd_chk("R5 result merge", 11'h408, 32'h00285834);
    wr(11'h000, 2);

    // R6 wrap bit
    wr(11'h414, 32'h3000);
    wr(11'h410, 32'h003CE000);
    tx_expect("R4 no pad enable", 32'h3000, 60, 0, 0);
    tx_finish(9'h000, 0);
    wr(11'h000, 1);
    wr(11'h41c, 32'h4000);
    wr(11'h418, 32'h00468000);
    wr(11'h400, 32'h00508000);
    tx_expect("R6 wrap", 32'h1000, 80, 0, 0);
    tx_finish(9'h000, -1);
    rd_chk("R9 no irq enable", 11'h000, 0);

    // R6 no skipping
    wr(11'h410, 32'h005AE000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R6 hold on not-ready", 32'(tx_valid), 0);
    end
    wr(11'h408, 32'h00328000);
    tx_expect("R6 resume", 32'h2000, 50, 0, 0);
    tx_finish(9'h000, -1);
    tx_expect("R6 next", 32'h3000, 90, 0, 0);
    tx_finish(9'h000, 0);
    wr(11'h000, 1);

    // R12 host priority over write-back
    wr(11'h400, 32'h001EC000);
    tx_expect("R12 launch", 32'h1000, 30, 0, 0);
    @(posedge clk); #1;
    tx_done = 1; tx_result = '0; host_req = 1; host_we = 0; host_addr = 11'h400;
    @(posedge clk); #1; tx_done = 0;
    repeat (3) begin @(posedge clk); #1; end
    check("R12 stalled", 32'(irq), 0);
    host_req = 0;
    @(posedge clk); #1; m_src[0] = 1'b1;
    rd_chk("R12 completes", 11'h000, 1);
    wr(11'h000, 1);

    // R7 incoming store
    wr(11'h420, 32'h0000C000);
    wr(11'h428, 32'h0000E000);
    rx_frame(68, 9'h000, 0, 2);
    rd_chk("R7 store", 11'h420, 32'h00444000);
    rd_chk("R9 rx ok event", 11'h000, 4);
    wr(11'h000, 4);
    rx_frame(72, 9'h002, 0, 3);
    rd_chk("R7 flags", 11'h428, 32'h00486002);
    rd_chk("R9 rx err event", 11'h000, 8);
    wr(11'h000, 8);

    // R8 busy after wrap lands on a used entry
    rx_frame(64, 9'h000, 1, -1);
    rd_chk("R8 busy event", 11'h000, 16);
    rd_chk("R8 untouched", 11'h420, 32'h00444000);
    wr(11'h000, 5'h0f);
    rd_chk("R10 zero bits keep", 11'h000, 16);
    wr(11'h000, 5'h10);
    rd_chk("R10 one bits clear", 11'h000, 0);
    wr(11'h420, 32'h0000C000);
    rx_frame(66, 9'h100, 0, 2);
    rd_chk("R7 wrap to first", 11'h420, 32'h00424100);
    wr(11'h000, 4);

    // R11 masking
    wr(11'h004, 0);
    rx_frame(70, 9'h000, 1, -1);
    @(negedge clk);
    check("R11 masked", 32'(irq), 0);
    wr(11'h004, 5'h10);
    @(negedge clk);
    check("R11 unmasked", 32'(irq), 1);
    wr(11'h000, 5'h10);
    @(negedge clk);
    check("R11 cleared", 32'(irq), 0);

    live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule